// File: doc/BRIEF.md
# Serial Receiver with Line Status Flags

This block turns an asynchronous serial bit stream into bytes and keeps a one-entry receive buffer next to a line status byte. It runs from a baud tick that pulses sixteen times per bit. A falling edge on the line starts a frame only if the line is still low half a bit later. From then on the line is sampled once per bit, at the middle of the bit. The word length is five to eight bits, and a parity bit can be added that is checked as even, odd or forced to a fixed value. Only the first stop bit is examined. A separate counter watches for the line staying low longer than the longest legal frame.

The surrounding logic reads the byte and the status through two read strobes. Reading the data clears the data-ready flag. Reading the status clears the four error flags. Two single-cycle event outputs feed an interrupt controller: one for a new byte and one for a newly raised error. A loopback select replaces the external line with the local transmit stream. The word length and parity settings are expected to stay unchanged while a frame is being received.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rxByte` is 0 and `lineStatus` is 0x60 while both transmit-empty inputs are 1. The `lineStatus` bits are: 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 `txHoldEmpty`, 6 `txShiftEmpty`, 7 zero.
- R2: A falling edge starts a frame only if the line is still low at the 8th baud tick after it is seen. A shorter low pulse is dropped: no byte is loaded and no flag changes.
- R3: Data bits arrive least significant bit first and are sampled every 16 ticks, at mid-bit. When the stop bit is sampled, the byte is loaded into `rxByte` and data ready is set.
- R4: `wordLenSel` gives 00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits. A shorter word is right-aligned in `rxByte` and its upper bits read as zero.
- R5: When `parityEn` is 1, the received parity bit is compared with the expected value and a mismatch sets the parity error flag. The expected value is `parityEven` when `parityStick` is 1. Otherwise it is the XOR of the data bits (even) or its inverse (odd).
- R6: A first stop bit sampled as 0 sets the framing error flag. Nothing after the first stop bit is checked, so a new start bit may follow directly after a single stop bit.
- R7: If a byte is loaded while data ready is still set and no data read happens in that cycle, the overrun flag is set. The buffer holds the newer byte.
- R8: The break flag is set when the line has been low for more than 12 bit times (192 ticks). A legal frame whose start, data and parity bits are all low does not set it.
- R9: A pulse on `rdData` clears data ready and leaves the error flags unchanged. A pulse on `rdStatus` clears the overrun, parity, framing and break flags and leaves data ready unchanged.
- R10: A flag that is set in the same cycle as its clearing read stays set.
- R11: With `loopEn` at 1, the receiver takes its bits from `loopData` and ignores `serialIn`.
- R12: `rxReadyEvt` pulses for one cycle when a byte is loaded, in the cycle in which data ready first reads 1. `lineErrEvt` pulses in the cycle in which any error flag is newly raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | External serial line, idle high |
| loopEn | input | 1 | Select the loopback stream instead of `serialIn` |
| loopData | input | 1 | Local transmit stream used in loopback |
| baudTick | input | 1 | Single-cycle pulse, 16 per bit |
| wordLenSel | input | 2 | Data bits per word: 00 = 5 up to 11 = 8 |
| parityEn | input | 1 | A parity bit follows the data |
| parityEven | input | 1 | Even parity, or the forced bit value in stick mode |
| parityStick | input | 1 | Parity bit forced to `parityEven` |
| rdData | input | 1 | Data register read strobe |
| rdStatus | input | 1 | Status register read strobe |
| txHoldEmpty | input | 1 | Transmit holding empty, shown in status bit 5 |
| txShiftEmpty | input | 1 | Transmitter fully idle, shown in status bit 6 |
| rxByte | output | 8 | Received byte, right-aligned |
| lineStatus | output | 8 | Line status byte |
| rxReadyEvt | output | 1 | New byte event |
| lineErrEvt | output | 1 | New error event |

## Verification
Two things can land on the same clock edge: a read that clears a flag, and the completion of a frame that sets that flag. The bench forces this by holding `rdStatus` and `rdData` high through the whole stop bit of a frame that has a parity error. It then releases them in the cycle in which `rxReadyEvt` appears. At that point the parity error and data-ready flags must both read 1. An ordinary frame and status read in an earlier step show that the clear works when nothing is being set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int MAX_DATA_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rxState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic startOk;      // start bit confirmed at mid-bit
    logic shiftBit;     // sample one data bit
    logic takeParity;   // sample the parity bit
    logic finishFrame;  // sample the first stop bit and load the buffer
  } rxStrobe_t;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      rxLine,
  input  logic [1:0] wordLenSel,
  input  logic      parityEn,
  output rxStrobe_t strobes
);

  localparam int CW       = $clog2(TICKS_PER_BIT);
  localparam int HALF     = TICKS_PER_BIT / 2;
  localparam int IW       = $clog2(MAX_DATA_BITS);

  rxState_t        state;
  logic [CW-1:0]   tickCnt;
  logic [IW-1:0]   bitIdx;
  logic            armed;

  logic atHalf;
  logic atEnd;
  logic lastBit;

  assign atHalf  = (tickCnt == CW'(HALF - 1));
  assign atEnd   = (tickCnt == CW'(TICKS_PER_BIT - 1));
  assign lastBit = (bitIdx == (IW'(wordLenSel) + IW'(MAX_DATA_BITS - 4)));

  always_comb begin
    strobes             = '0;
    strobes.startOk     = baudTick && (state == RX_START) && atHalf && !rxLine;
    strobes.shiftBit    = baudTick && (state == RX_DATA) && atEnd;
    strobes.takeParity  = baudTick && (state == RX_PARITY) && atEnd;
    strobes.finishFrame = baudTick && (state == RX_STOP) && atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      armed   <= 1'b0;
    end else if (baudTick) begin
      unique case (state)
        RX_IDLE: begin
          tickCnt <= '0;
          if (rxLine) begin
            armed <= 1'b1;
          end else if (armed) begin
            armed <= 1'b0;
            state <= RX_START;
          end
        end
        RX_START: begin
          if (atHalf) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxLine ? RX_IDLE : RX_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (atEnd) begin
            tickCnt <= '0;
            bitIdx  <= bitIdx + 1'b1;
            if (lastBit) state <= parityEn ? RX_PARITY : RX_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_PARITY: begin
          if (atEnd) begin
            tickCnt <= '0;
            state   <= RX_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (atEnd) begin
            tickCnt <= '0;
            state   <= RX_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_rx_datapath.sv
module uart_rx_datapath
  import uart_rx_pkg::*;
#(
  parameter int BREAK_TICKS = 192,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     baudTick,
  input  logic                     serialIn,
  input  logic                     loopEn,
  input  logic                     loopData,
  input  logic [1:0]               wordLenSel,
  input  logic                     parityEn,
  input  logic                     parityEven,
  input  logic                     parityStick,
  input  logic                     rdData,
  input  logic                     rdStatus,
  input  rxStrobe_t                strobes,
  output logic                     rxLine,
  output logic [MAX_DATA_BITS-1:0] rxByte,
  output logic                     dataReady,
  output logic                     overrunErr,
  output logic                     parityErr,
  output logic                     framingErr,
  output logic                     breakErr,
  output logic                     rxReadyEvt,
  output logic                     lineErrEvt
);

  localparam int BW = $clog2(BREAK_TICKS + 2);
  localparam int SW = $clog2(MAX_DATA_BITS);

  // input select and synchroniser
  logic                   lineMux;
  logic [SYNC_STAGES-1:0] syncQ;

  assign lineMux = loopEn ? loopData : serialIn;
  assign rxLine  = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineMux};
  end

  // shift register, data enters at the top
  logic [MAX_DATA_BITS-1:0] shiftReg;
  logic                     parityBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else begin
      if (strobes.startOk)         shiftReg  <= '0;
      else if (strobes.shiftBit)   shiftReg  <= {rxLine, shiftReg[MAX_DATA_BITS-1:1]};
      if (strobes.takeParity)      parityBit <= rxLine;
    end
  end

  // right alignment and parity evaluation
  logic [SW-1:0]            alignShift;
  logic [MAX_DATA_BITS-1:0] aligned;
  logic                     dataXor;
  logic                     expParity;
  logic                     parityBad;

  assign alignShift = SW'(MAX_DATA_BITS - 5) - SW'(wordLenSel);
  assign aligned    = shiftReg >> alignShift;
  assign dataXor    = ^aligned;

  always_comb begin
    if (parityStick)     expParity = parityEven;
    else if (parityEven) expParity = dataXor;
    else                 expParity = ~dataXor;
  end

  assign parityBad = parityEn && (parityBit != expParity);

  // break detector: ticks spent low, saturating one past the limit
  logic [BW-1:0] lowCnt;
  logic          breakHit;

  assign breakHit = baudTick && !rxLine && (lowCnt == BW'(BREAK_TICKS));

  always_ff @(posedge clk) begin
    if (!rstN)                                      lowCnt <= '0;
    else if (rxLine)                                lowCnt <= '0;
    else if (baudTick && lowCnt != BW'(BREAK_TICKS + 1)) lowCnt <= lowCnt + 1'b1;
  end

  // flag set and clear, a set wins over a clearing read
  logic load;
  logic setOe, setPe, setFe, setBi;

  assign load  = strobes.finishFrame;
  assign setOe = load && dataReady && !rdData;
  assign setPe = load && parityBad;
  assign setFe = load && !rxLine;
  assign setBi = breakHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte     <= '0;
      dataReady  <= 1'b0;
      overrunErr <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakErr   <= 1'b0;
      rxReadyEvt <= 1'b0;
      lineErrEvt <= 1'b0;
    end else begin
      if (load) rxByte <= aligned;
      dataReady  <= load  || (dataReady  && !rdData);
      overrunErr <= setOe || (overrunErr && !rdStatus);
      parityErr  <= setPe || (parityErr  && !rdStatus);
      framingErr <= setFe || (framingErr && !rdStatus);
      breakErr   <= setBi || (breakErr   && !rdStatus);
      rxReadyEvt <= load;
      lineErrEvt <= setOe || setPe || setFe || setBi;
    end
  end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT  = 16,
  parameter int MAX_FRAME_BITS = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  input  logic       loopEn,
  input  logic       loopData,
  input  logic       baudTick,
  input  logic [1:0] wordLenSel,
  input  logic       parityEn,
  input  logic       parityEven,
  input  logic       parityStick,
  input  logic       rdData,
  input  logic       rdStatus,
  input  logic       txHoldEmpty,
  input  logic       txShiftEmpty,
  output logic [7:0] rxByte,
  output logic [7:0] lineStatus,
  output logic       rxReadyEvt,
  output logic       lineErrEvt
);

  localparam int BREAK_TICKS = TICKS_PER_BIT * MAX_FRAME_BITS;

  rxStrobe_t strobes;
  logic      rxLine;
  logic      dataReady, overrunErr, parityErr, framingErr, breakErr;

  uart_rx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .baudTick  (baudTick),
    .rxLine    (rxLine),
    .wordLenSel(wordLenSel),
    .parityEn  (parityEn),
    .strobes   (strobes)
  );

  uart_rx_datapath #(
    .BREAK_TICKS(BREAK_TICKS),
    .SYNC_STAGES(2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .serialIn   (serialIn),
    .loopEn     (loopEn),
    .loopData   (loopData),
    .wordLenSel (wordLenSel),
    .parityEn   (parityEn),
    .parityEven (parityEven),
    .parityStick(parityStick),
    .rdData     (rdData),
    .rdStatus   (rdStatus),
    .strobes    (strobes),
    .rxLine     (rxLine),
    .rxByte     (rxByte),
    .dataReady  (dataReady),
    .overrunErr (overrunErr),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .breakErr   (breakErr),
    .rxReadyEvt (rxReadyEvt),
    .lineErrEvt (lineErrEvt)
  );

  assign lineStatus = {1'b0, txShiftEmpty, txHoldEmpty, breakErr,
                       framingErr, parityErr, overrunErr, dataReady};

endmodule

// File: rtl/uart_rx_status_checks.sv
module uart_rx_status_checks (
  input logic       clk,
  input logic       rstN,
  input logic       rdData,
  input logic       rdStatus,
  input logic [1:0] wordLenSel,
  input logic [7:0] rxByte,
  input logic [7:0] lineStatus,
  input logic       rxReadyEvt,
  input logic       lineErrEvt
);

  assert_dr_rise_evt_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineStatus[0]) |-> rxReadyEvt);

  assert_byte_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rxReadyEvt |-> $stable(rxByte));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxReadyEvt && wordLenSel == 2'b00) |-> (rxByte[7:5] == 3'b000));

  assert_oe_needs_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineStatus[1]) |-> $past(lineStatus[0]));

  assert_dr_clear_by_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineStatus[0]) |-> $past(rdData));

  assert_err_clear_by_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(lineStatus[1]) || $fell(lineStatus[2]) ||
     $fell(lineStatus[3]) || $fell(lineStatus[4])) |-> $past(rdStatus));

  assert_err_evt_flag_R12: assert property (@(posedge clk) disable iff (!rstN)
    lineErrEvt |-> (lineStatus[4:1] != 4'b0000));

  assert_evt_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    rxReadyEvt |=> !rxReadyEvt);

endmodule

bind uart_rx_status uart_rx_status_checks u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .rdData    (rdData),
  .rdStatus  (rdStatus),
  .wordLenSel(wordLenSel),
  .rxByte    (rxByte),
  .lineStatus(lineStatus),
  .rxReadyEvt(rxReadyEvt),
  .lineErrEvt(lineErrEvt)
);

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;

  logic clk = 1'b0;
  logic rstN, serialIn, loopEn, loopData, baudTick;
  logic [1:0] wordLenSel;
  logic parityEn, parityEven, parityStick, rdData, rdStatus;
  logic txHoldEmpty, txShiftEmpty;
  logic [7:0] rxByte, lineStatus;
  logic rxReadyEvt, lineErrEvt;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .loopEn(loopEn),
    .loopData(loopData), .baudTick(baudTick), .wordLenSel(wordLenSel),
    .parityEn(parityEn), .parityEven(parityEven), .parityStick(parityStick),
    .rdData(rdData), .rdStatus(rdStatus), .txHoldEmpty(txHoldEmpty),
    .txShiftEmpty(txShiftEmpty), .rxByte(rxByte), .lineStatus(lineStatus),
    .rxReadyEvt(rxReadyEvt), .lineErrEvt(lineErrEvt)
  );

  typedef struct {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  int  tickPhase = 0;
  bit  autoMode = 1'b0;
  bit  useLoop = 1'b0;
  bit  done = 1'b0;

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    baudTick = 1'b0;
    forever begin
      @(negedge clk);
      baudTick  = (tickPhase == TICK_DIV - 1);
      tickPhase = (tickPhase + 1) % TICK_DIV;
    end
  end

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit parBit(input logic [7:0] d, input bit even, input bit stick);
    if (stick) return even;
    return even ? ^d : ~^d;
  endfunction

  task automatic putLine(input bit v, input int clks = BIT_CLKS);
    if (useLoop) loopData = v; else serialIn = v;
    repeat (clks) @(negedge clk);
  endtask

  task automatic sendBody(input logic [7:0] d, input int nBits,
                          input bit parOn, input bit parVal);
    putLine(1'b0);
    for (int i = 0; i < nBits; i++) putLine(d[i]);
    if (parOn) putLine(parVal);
  endtask

  // driver: pushes the expected item then drives the frame
  task automatic sendFrame(input logic [7:0] d, input int nBits, input bit parOn,
                           input bit parVal, input bit stopVal, input bit expPe,
                           input string req);
    expItem_t it;
    logic [7:0] mask;
    mask = 8'((1 << nBits) - 1);
    it.data = d & mask;
    it.pe   = expPe;
    it.fe   = ~stopVal;
    it.req  = req;
    if (autoMode) expQ.push_back(it);
    sendBody(d, nBits, parOn, parVal);
    putLine(stopVal);
  endtask

  task automatic sendGood(input logic [7:0] d, input string req);
    int nb;
    logic [7:0] m;
    nb = int'(wordLenSel) + 5;
    m  = d & 8'((1 << nb) - 1);
    sendFrame(d, nb, parityEn, parBit(m, parityEven, parityStick), 1'b1, 1'b0, req);
  endtask

  task automatic pulseRead(input bit dataRd, input bit statRd);
    rdData = dataRd;
    rdStatus = statRd;
    @(negedge clk);
    rdData = 1'b0;
    rdStatus = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops expected items as bytes arrive
  initial begin
    forever begin
      @(negedge clk);
      if (rxReadyEvt && autoMode) begin
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R2 unexpected byte: actual %0h expected none", rxByte);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(it.req, rxByte, it.data, "byte");
          check("R5", lineStatus[2], it.pe, "parity flag");
          check("R6", lineStatus[3], it.fe, "framing flag");
          check("R12", lineErrEvt, it.pe | it.fe, "error event");
          check("R3", lineStatus[0], 1, "data ready");
        end
        rdData = 1'b1;
        rdStatus = 1'b1;
        @(negedge clk);
        rdData = 1'b0;
        rdStatus = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; serialIn = 1'b1; loopEn = 1'b0; loopData = 1'b1;
    wordLenSel = 2'b11; parityEn = 1'b0; parityEven = 1'b0; parityStick = 1'b0;
    rdData = 1'b0; rdStatus = 1'b0; txHoldEmpty = 1'b1; txShiftEmpty = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", lineStatus, 8'h60, "status after reset");
    check("R1", rxByte, 8'h00, "byte after reset");
    putLine(1'b1);

    // R3 / R6: back-to-back 8-bit frames with one stop bit
    autoMode = 1'b1;
    sendGood(8'hA5, "R3");
    sendGood(8'h3C, "R6");
    sendGood(8'hFF, "R3");
    sendGood(8'h00, "R3");
    putLine(1'b1, 2 * BIT_CLKS);

    // R4: short words right-aligned
    wordLenSel = 2'b00; sendGood(8'hF5, "R4");
    wordLenSel = 2'b01; sendGood(8'hEA, "R4");
    wordLenSel = 2'b10; sendGood(8'hD5, "R4");
    putLine(1'b1, BIT_CLKS);

    // R5: parity modes
    parityEn = 1'b1; parityEven = 1'b1;
    sendGood(8'h5B, "R5");
    sendFrame(8'h5B, 7, 1'b1, ~parBit(8'h5B, 1'b1, 1'b0), 1'b1, 1'b1, "R5");
    parityEven = 1'b0;
    sendGood(8'h13, "R5");
    parityStick = 1'b1; parityEven = 1'b1;
    sendGood(8'h22, "R5");
    sendFrame(8'h22, 7, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
    parityStick = 1'b0; parityEn = 1'b0; wordLenSel = 2'b11;
    putLine(1'b1, BIT_CLKS);

    // R6: stop bit low
    sendFrame(8'h81, 8, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
    putLine(1'b1, 2 * BIT_CLKS);
    check("R9", lineStatus[4:0], 5'b0, "flags after reads");

    // R2: short low pulse is not a start
    putLine(1'b0, 4 * TICK_DIV);
    putLine(1'b1, 3 * BIT_CLKS);
    check("R2", lineStatus[0], 0, "no data after glitch");
    check("R2", expQ.size(), 0, "no pending items");
    sendGood(8'h6E, "R2");
    putLine(1'b1, BIT_CLKS);

    // R7: overrun
    autoMode = 1'b0;
    sendGood(8'h11, "R7");
    sendGood(8'h22, "R7");
    putLine(1'b1, BIT_CLKS);
    check("R7", lineStatus[1:0], 2'b11, "overrun and ready");
    check("R7", rxByte, 8'h22, "newer byte kept");
    pulseRead(1'b1, 1'b0);
    check("R9", lineStatus[1:0], 2'b10, "data read keeps overrun");
    pulseRead(1'b0, 1'b1);
    check("R9", lineStatus[1:0], 2'b00, "status read clears overrun");

    // R10: reads held through the loading edge
    parityEn = 1'b1; parityEven = 1'b1;
    sendBody(8'h47, 8, 1'b1, ~parBit(8'h47, 1'b1, 1'b0));
    serialIn = 1'b1;
    rdData = 1'b1; rdStatus = 1'b1;
    for (int k = 0; k < BIT_CLKS; k++) begin
      @(negedge clk);
      if (rxReadyEvt) break;
    end
    rdData = 1'b0; rdStatus = 1'b0;
    check("R10", rxReadyEvt, 1, "load seen");
    check("R10", lineStatus[2], 1, "parity flag survives read");
    check("R10", lineStatus[0], 1, "ready survives read");
    check("R10", rxByte, 8'h47, "byte");
    putLine(1'b1, BIT_CLKS);
    pulseRead(1'b1, 1'b1);
    check("R9", lineStatus[4:0], 5'b0, "cleared after reads");

    // R8: all-low legal frame, then a real break
    sendFrame(8'h00, 8, 1'b1, 1'b0, 1'b1, 1'b0, "R8");
    putLine(1'b1, BIT_CLKS);
    check("R8", lineStatus[4], 0, "no break on legal frame");
    check("R8", lineStatus[0], 1, "zero byte received");
    pulseRead(1'b1, 1'b1);
    putLine(1'b0, 14 * BIT_CLKS);
    putLine(1'b1, 2 * BIT_CLKS);
    check("R8", lineStatus[4], 1, "break flag");
    check("R6", lineStatus[3], 1, "framing on break");
    pulseRead(1'b1, 1'b1);
    check("R9", lineStatus[4:0], 5'b0, "break cleared");
    parityEn = 1'b0;

    // R11: loopback ignores the external line
    autoMode = 1'b1;
    loopEn = 1'b1;
    @(negedge clk);
    serialIn = 1'b0;
    useLoop = 1'b1;
    putLine(1'b1, BIT_CLKS);
    sendGood(8'hC3, "R11");
    putLine(1'b1, BIT_CLKS);
    useLoop = 1'b0;
    serialIn = 1'b1;
    putLine(1'b1, BIT_CLKS);
    loopEn = 1'b0;
    putLine(1'b1, BIT_CLKS);

    check("R3", expQ.size(), 0, "all expected bytes seen");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule